// File: doc/BRIEF.md
# Lock Arbiter with Expiry Watchdog

This block lets several host clients share one serial controller by owning a software lock in turn. A client claims the lock with an atomic read-modify-write cycle that sets the lock bit. The word returned by that cycle tells the client whether it won. The owner gives the lock back with a plain write that clears the bit. Every hand-back, voluntary or forced, advances a key counter. A client that notes the key when it acquires can therefore tell later whether it still owns the lock.

A millisecond tick drives a watchdog that runs only while the lock is held. If the owner keeps the lock longer than the programmed limit, the block takes the lock back, raises an error flag and pulses a forced-release event. It also restores the limit to its default of 250 ms. The default width of the limit field is 20 bits; a narrower build (10 bits) suits a slower controller.

Bus word at the lock address: key count in bits 31:2, lock bit in bit 1, error flag in bit 0. Address 0 selects the lock word and address 1 selects the timeout limit.

Top module: `lockwd_top`

## Requirements
- R1: After a synchronous reset the lock, key, error flag and forced-release output are 0, the timeout limit reads 250 and the captured RMW word is 0.
- R2: A read-modify-write to address 0 with bit 1 set acquires a free lock: `lock_o` is high after that clock edge and `rmw_rdata` holds the previous lock word (bit 1 = 0).
- R3: A read-modify-write with bit 1 set leaves a held lock and the key unchanged, and returns a word with bit 1 = 1. A plain write with bit 1 set never acquires the lock.
- R4: A plain write or read-modify-write to address 0 with bit 1 clear releases a held lock: the lock falls, the key increments by one, the error flag clears and the watchdog stops.
- R5: With limit T, the lock expires on the tick that brings the number of ticks since acquisition (or since the last restart) to T. At that edge the lock falls, the key increments by one, the error flag sets, and `forced_rel_o` is high for exactly that one cycle.
- R6: An expiry reloads the timeout limit with 250.
- R7: A write to address 1 loads the limit from the low TMO_W data bits and restarts the tick count from zero.
- R8: The error flag stays set until a write with bit 1 clear reaches address 0. Such a write to a free lock clears the flag without changing the key.
- R9: When a release write and an expiring tick arrive in the same cycle, the release wins: no error flag and no forced-release pulse.
- R10: A limit of 0 expires on the first tick after acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| bus_wr | input | 1 | Plain write strobe |
| bus_rmw | input | 1 | Atomic read-modify-write strobe (write half carries the modified word) |
| bus_addr | input | 1 | 0 = lock word, 1 = timeout limit |
| bus_wdata | input | DATA_W | Write data |
| rmw_rdata | output | DATA_W | Lock word as it stood when the last RMW to address 0 was applied |
| lock_o | output | 1 | Lock held |
| key_o | output | DATA_W-2 | Release counter |
| tmo_err_o | output | 1 | Timeout error flag |
| forced_rel_o | output | 1 | One-cycle pulse on watchdog release |
| timeout_o | output | TMO_W | Current timeout limit in ms |

## Verification
Directed sequences first cover contention: a second RMW on a held lock, and a plain set-write that must not acquire. They then separate a restart of the count by a limit write from a real expiry, and show the limit of 0 against a limit of 5. The same-cycle release-and-tick case is run on its own to show release priority. A seeded random phase then mixes acquisitions, both release forms, limit writes of 0 to 7 and sparse ticks. This checks the key counting and the error flag against a bench model over long interleavings that no directed case reaches.

// File: rtl/lockwd_pkg.sv
package lockwd_pkg;

  typedef enum logic {
    SEL_LOCKWORD = 1'b0,
    SEL_LIMIT    = 1'b1
  } reg_sel_e;

  // decoded bus request for one cycle
  typedef struct packed {
    logic claim;    // RMW asking to set the lock bit
    logic giveback; // write or RMW clearing the lock bit
    logic limit_wr; // write to the timeout limit
    logic snap;     // RMW on the lock word: capture old word
  } bus_req_t;

endpackage

// File: rtl/lockwd_decode.sv
module lockwd_decode
  import lockwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic              bus_rmw,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output bus_req_t          req
);

  localparam int LOCK_BIT = 1;

  reg_sel_e sel;
  logic     any_wr;

  assign sel    = reg_sel_e'(bus_addr);
  assign any_wr = bus_wr | bus_rmw;

  always_comb begin
    req          = '0;
    req.limit_wr = any_wr && (sel == SEL_LIMIT);
    req.snap     = bus_rmw && (sel == SEL_LOCKWORD);
    req.claim    = bus_rmw && (sel == SEL_LOCKWORD) && bus_wdata[LOCK_BIT];
    req.giveback = any_wr && (sel == SEL_LOCKWORD) && !bus_wdata[LOCK_BIT];
  end

endmodule

// File: rtl/lockwd_timer.sv
module lockwd_timer #(
  parameter int TMO_W      = 20,
  parameter int DEFAULT_MS = 250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             held_i,
  input  logic             claim_ok_i,
  input  logic             giveback_i,
  input  logic             limit_wr_i,
  input  logic [TMO_W-1:0] limit_data_i,
  output logic             expire_o,
  output logic [TMO_W-1:0] limit_o
);

  localparam logic [TMO_W-1:0] LIMIT_RST = TMO_W'(DEFAULT_MS);

  logic [TMO_W-1:0] count_q;
  logic [TMO_W-1:0] limit_q;
  logic [TMO_W:0]   count_inc;

  assign count_inc = {1'b0, count_q} + 1'b1;

  // a release or limit write in the same cycle takes priority over expiry
  assign expire_o = held_i && tick_i && !limit_wr_i && !giveback_i &&
                    (count_inc >= {1'b0, limit_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (!held_i || claim_ok_i || limit_wr_i) begin
      count_q <= '0;
    end else if (tick_i && !count_inc[TMO_W]) begin
      count_q <= count_inc[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= LIMIT_RST;
    end else if (expire_o) begin
      limit_q <= LIMIT_RST;
    end else if (limit_wr_i) begin
      limit_q <= limit_data_i;
    end
  end

  assign limit_o = limit_q;

endmodule

// File: rtl/lockwd_owner.sv
module lockwd_owner
  import lockwd_pkg::*;
#(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  bus_req_t         req,
  input  logic             expire_i,
  output logic             claim_ok_o,
  output logic             held_o,
  output logic [KEY_W-1:0] key_o,
  output logic             err_o,
  output logic             forced_o
);

  logic             held_q;
  logic             err_q;
  logic             forced_q;
  logic [KEY_W-1:0] key_q;
  logic             release_ok;

  assign claim_ok_o = req.claim && !held_q;
  assign release_ok = req.giveback && held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= 1'b0;
      err_q    <= 1'b0;
      key_q    <= '0;
      forced_q <= 1'b0;
    end else begin
      forced_q <= expire_i;
      if (release_ok) begin
        held_q <= 1'b0;
        key_q  <= key_q + 1'b1;
        err_q  <= 1'b0;
      end else if (expire_i) begin
        held_q <= 1'b0;
        key_q  <= key_q + 1'b1;
        err_q  <= 1'b1;
      end else if (claim_ok_o) begin
        held_q <= 1'b1;
      end
      if (req.giveback && !held_q) begin
        err_q <= 1'b0;
      end
    end
  end

  assign held_o   = held_q;
  assign key_o    = key_q;
  assign err_o    = err_q;
  assign forced_o = forced_q;

endmodule

// File: rtl/lockwd_top.sv
module lockwd_top
  import lockwd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int TMO_W      = 20,
  parameter int DEFAULT_MS = 250
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_ms,
  input  logic                bus_wr,
  input  logic                bus_rmw,
  input  logic                bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   rmw_rdata,
  output logic                lock_o,
  output logic [DATA_W-3:0]   key_o,
  output logic                tmo_err_o,
  output logic                forced_rel_o,
  output logic [TMO_W-1:0]    timeout_o
);

  localparam int KEY_W = DATA_W - 2;

  bus_req_t         req;
  logic             claim_ok;
  logic             expire;
  logic             held;
  logic             err;
  logic [KEY_W-1:0] key;
  logic [DATA_W-1:0] rdata_q;

  lockwd_decode #(.DATA_W(DATA_W)) u_dec (
    .bus_wr    (bus_wr),
    .bus_rmw   (bus_rmw),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .req       (req)
  );

  lockwd_owner #(.KEY_W(KEY_W)) u_own (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .expire_i   (expire),
    .claim_ok_o (claim_ok),
    .held_o     (held),
    .key_o      (key),
    .err_o      (err),
    .forced_o   (forced_rel_o)
  );

  lockwd_timer #(.TMO_W(TMO_W), .DEFAULT_MS(DEFAULT_MS)) u_tmr (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_ms),
    .held_i       (held),
    .claim_ok_i   (claim_ok),
    .giveback_i   (req.giveback),
    .limit_wr_i   (req.limit_wr),
    .limit_data_i (bus_wdata[TMO_W-1:0]),
    .expire_o     (expire),
    .limit_o      (timeout_o)
  );

  // read half of the atomic cycle: the word as it stood before the write half
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (req.snap) begin
      rdata_q <= {key, held, err};
    end
  end

  assign rmw_rdata = rdata_q;
  assign lock_o    = held;
  assign key_o     = key;
  assign tmo_err_o = err;

endmodule

// File: rtl/lockwd_checker.sv
module lockwd_checker #(
  parameter int DATA_W     = 32,
  parameter int TMO_W      = 20,
  parameter int DEFAULT_MS = 250
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_ms,
  input logic              bus_wr,
  input logic              bus_rmw,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              lock_o,
  input logic [DATA_W-3:0] key_o,
  input logic              tmo_err_o,
  input logic              forced_rel_o,
  input logic [TMO_W-1:0]  timeout_o
);

  localparam int KEY_W = DATA_W - 2;

  AST_KEY_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_o) |-> ($fell(lock_o) && key_o == KEY_W'($past(key_o) + 1'b1))); // R4

  AST_RISE_NEEDS_RMW: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(bus_rmw && !bus_addr && bus_wdata[1])); // R2

  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (lock_o && bus_rmw && !bus_addr && bus_wdata[1] && !tick_ms) |=> (lock_o && $stable(key_o))); // R3

  AST_PLAIN_SET_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (!lock_o && bus_wr && !bus_rmw && !bus_addr && bus_wdata[1]) |=> !lock_o); // R3

  AST_FORCED_EFFECT: assert property (@(posedge clk) disable iff (rst)
    forced_rel_o |-> ($fell(lock_o) && tmo_err_o)); // R5

  AST_FORCED_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    forced_rel_o |=> !forced_rel_o); // R5

  AST_FORCED_RELOAD: assert property (@(posedge clk) disable iff (rst)
    forced_rel_o |-> (timeout_o == TMO_W'(DEFAULT_MS))); // R6

  AST_ERR_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err_o) |-> forced_rel_o); // R8

  AST_RELEASE_WINS: assert property (@(posedge clk) disable iff (rst)
    (lock_o && bus_wr && !bus_rmw && !bus_addr && !bus_wdata[1]) |=>
      (!lock_o && !tmo_err_o && !forced_rel_o)); // R9

endmodule

bind lockwd_top lockwd_checker #(
  .DATA_W(DATA_W), .TMO_W(TMO_W), .DEFAULT_MS(DEFAULT_MS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick_ms      (tick_ms),
  .bus_wr       (bus_wr),
  .bus_rmw      (bus_rmw),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .lock_o       (lock_o),
  .key_o        (key_o),
  .tmo_err_o    (tmo_err_o),
  .forced_rel_o (forced_rel_o),
  .timeout_o    (timeout_o)
);

// File: tb/tb_lockwd_top.sv
`timescale 1ns/1ps
module tb_lockwd_top;

  localparam int DATA_W = 32;
  localparam int TMO_W  = 20;
  localparam int DEF_MS = 250;
  localparam int KEY_W  = DATA_W - 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_ms = 1'b0;
  logic              bus_wr = 1'b0;
  logic              bus_rmw = 1'b0;
  logic              bus_addr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] rmw_rdata;
  logic              lock_o;
  logic [KEY_W-1:0]  key_o;
  logic              tmo_err_o;
  logic              forced_rel_o;
  logic [TMO_W-1:0]  timeout_o;

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  logic              m_lock = 1'b0;
  logic              m_err = 1'b0;
  logic              m_forced = 1'b0;
  logic [KEY_W-1:0]  m_key = '0;
  logic [TMO_W-1:0]  m_limit = TMO_W'(DEF_MS);
  logic [TMO_W-1:0]  m_count = '0;
  logic [DATA_W-1:0] m_rd = '0;

  always #2 clk = ~clk;

  lockwd_top #(.DATA_W(DATA_W), .TMO_W(TMO_W), .DEFAULT_MS(DEF_MS)) dut (
    .clk(clk), .rst(rst), .tick_ms(tick_ms), .bus_wr(bus_wr), .bus_rmw(bus_rmw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rmw_rdata(rmw_rdata),
    .lock_o(lock_o), .key_o(key_o), .tmo_err_o(tmo_err_o),
    .forced_rel_o(forced_rel_o), .timeout_o(timeout_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "lock",   32'(lock_o),       32'(m_lock));
    chk(tag, "key",    32'(key_o),        32'(m_key));
    chk(tag, "err",    32'(tmo_err_o),    32'(m_err));
    chk(tag, "forced", 32'(forced_rel_o), 32'(m_forced));
    chk(tag, "limit",  32'(timeout_o),    32'(m_limit));
    chk(tag, "rdata",  rmw_rdata,         m_rd);
  endtask

  // next model state for one clock edge, derived from R2..R10
  task automatic model_edge(input logic wr, input logic rmw, input logic addr,
                            input logic [31:0] wd, input logic tk);
    logic claim, give, lim, expire;
    logic [TMO_W:0] inc;
    claim  = rmw && !addr && wd[1];
    give   = (wr || rmw) && !addr && !wd[1];
    lim    = (wr || rmw) && addr;
    inc    = {1'b0, m_count} + 1'b1;
    expire = m_lock && tk && !lim && !give && (inc >= {1'b0, m_limit});
    if (rmw && !addr) m_rd = {m_key, m_lock, m_err};
    m_forced = expire;
    if (!m_lock || lim) m_count = '0;
    else if (tk) m_count = inc[TMO_W-1:0];
    if (give && m_lock) begin
      m_lock = 1'b0; m_key = m_key + 1'b1; m_err = 1'b0;
    end else if (expire) begin
      m_lock = 1'b0; m_key = m_key + 1'b1; m_err = 1'b1;
      m_limit = TMO_W'(DEF_MS);
    end else if (claim && !m_lock) begin
      m_lock = 1'b1; m_count = '0;
    end
    if (give && !m_lock && !expire) m_err = 1'b0;
    if (lim) m_limit = wd[TMO_W-1:0];
  endtask

  // drive one cycle from a negedge, return at the following negedge
  task automatic step(input logic wr, input logic rmw, input logic addr,
                      input logic [31:0] wd, input logic tk);
    bus_wr = wr; bus_rmw = rmw; bus_addr = addr; bus_wdata = wd; tick_ms = tk;
    model_edge(wr, rmw, addr, wd, tk);
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rmw = 1'b0; bus_addr = 1'b0; bus_wdata = '0; tick_ms = 1'b0;
  endtask

  task automatic idle_tick(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check_all("R1");
    chk("R1", "limit default", 32'(timeout_o), 32'd250);

    // R7: load a limit of 5
    step(1'b1, 1'b0, 1'b1, 32'hFFF0_0005, 1'b0);
    chk("R7", "limit", 32'(timeout_o), 32'd5);
    check_all("R7");

    // R2: acquire a free lock, old word shows bit1 = 0
    step(1'b0, 1'b1, 1'b0, 32'h0000_0002, 1'b0);
    chk("R2", "lock", 32'(lock_o), 32'd1);
    chk("R2", "rdata", rmw_rdata, 32'h0);
    check_all("R2");

    // R3: second claim fails, returns bit1 = 1; plain set-write has no effect
    step(1'b0, 1'b1, 1'b0, 32'h0000_0006, 1'b0);
    chk("R3", "rdata bit1", 32'(rmw_rdata[1]), 32'd1);
    check_all("R3");
    step(1'b1, 1'b0, 1'b0, 32'h0000_0002, 1'b0);
    check_all("R3");

    // R7: three ticks, restart by limit write, four more ticks: still held
    idle_tick(3);
    step(1'b1, 1'b0, 1'b1, 32'h5, 1'b0);
    idle_tick(4);
    chk("R7", "lock after restart", 32'(lock_o), 32'd1);
    check_all("R7");

    // R5/R6: fifth tick expires
    idle_tick(1);
    chk("R5", "lock", 32'(lock_o), 32'd0);
    chk("R5", "forced", 32'(forced_rel_o), 32'd1);
    chk("R5", "key", 32'(key_o), 32'd1);
    chk("R6", "limit", 32'(timeout_o), 32'd250);
    check_all("R5");
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    chk("R5", "forced one cycle", 32'(forced_rel_o), 32'd0);
    chk("R8", "err held", 32'(tmo_err_o), 32'd1);

    // R8: clear-write on free lock clears err, key unchanged
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b0);
    chk("R8", "err", 32'(tmo_err_o), 32'd0);
    chk("R8", "key", 32'(key_o), 32'd1);

    // R4: acquire then plain release
    step(1'b0, 1'b1, 1'b0, 32'h2, 1'b0);
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b1);
    chk("R4", "lock", 32'(lock_o), 32'd0);
    chk("R4", "key", 32'(key_o), 32'd2);
    check_all("R4");
    // R4: release by RMW form
    step(1'b0, 1'b1, 1'b0, 32'h2, 1'b0);
    step(1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R4", "key rmw release", 32'(key_o), 32'd3);

    // R10: limit 0 expires on first tick
    step(1'b1, 1'b0, 1'b1, 32'h0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 32'h2, 1'b0);
    idle_tick(1);
    chk("R10", "forced", 32'(forced_rel_o), 32'd1);
    chk("R10", "lock", 32'(lock_o), 32'd0);
    check_all("R10");

    // R9: release and expiring tick in the same cycle
    step(1'b1, 1'b0, 1'b1, 32'h1, 1'b0);
    step(1'b0, 1'b1, 1'b0, 32'h2, 1'b0);
    step(1'b1, 1'b0, 1'b0, 32'h0, 1'b1);
    chk("R9", "err", 32'(tmo_err_o), 32'd0);
    chk("R9", "forced", 32'(forced_rel_o), 32'd0);
    chk("R9", "lock", 32'(lock_o), 32'd0);
    check_all("R9");

    // random mix against the model (R2..R8)
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [31:0] w;
      logic tk;
      r  = $urandom % 16;
      w  = $urandom;
      tk = (($urandom % 3) == 0);
      case (r)
        0, 1, 2: step(1'b0, 1'b1, 1'b0, w | 32'h2, tk);
        3:       step(1'b1, 1'b0, 1'b0, w & ~32'h2, tk);
        4:       step(1'b0, 1'b1, 1'b0, w & ~32'h2, tk);
        5:       step(1'b1, 1'b0, 1'b1, (w & 32'hFFF0_0000) | 32'($urandom % 8), tk);
        6:       step(1'b1, 1'b0, 1'b0, w | 32'h2, tk);
        default: step(1'b0, 1'b0, 1'b0, 32'h0, tk);
      endcase
      check_all("R4 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule